// File: doc/BRIEF.md
# Framed Serial Transmitter with Double-Buffered Data

This block sends host words out as a framed serial bit stream. The host writes a word into a holding register. When a frame sync is seen, that word moves into a separate shift register and leaves on the data pin one bit per serial clock, most significant bit first. Because the holding register is free again as soon as the copy is made, the host can write the next word while the current one is still shifting. When frames arrive back to back, words follow each other with no idle bit between them.

The serial clock and the frame sync each come from one of two sources, chosen independently: an internal generator or an outside pin. The word length is chosen at run time from six sizes. The polarity of the clock pin and of the frame pin are each programmable. Everything runs in the system clock domain. An external serial clock or frame sync is assumed to be synchronous to the system clock and slower than half its rate. Configuration is changed only while reset is held.

Top module: `serial_tx_port`

## Requirements
- R1: While reset is held and in the cycle after it, `tx_ready` is 1, `underrun` is 0, `sdata_o` is 0, `sclk_o` equals `cfg_clk_pol` and `fsync_o` equals `cfg_fs_pol`.
- R2: `cfg_len` selects the word length: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32 bits. The word is taken from the low bits of `wr_data` and sent most significant bit first.
- R3: The bit clock is defined at its unpolarised level (pin XOR polarity). Frame sync is sampled on its rising edges. The first bit of a word is driven on the first falling edge after a rising edge that sampled frame sync active, and each later falling edge drives the next bit. Once the word is done, each falling edge drives 0. `sdata_o` changes only on a falling edge.
- R4: A host write clears `tx_ready` in the next cycle. A frame that copies a full holding register into the shift register sets `tx_ready`. A write during shifting does not disturb the word being sent.
- R5: A frame that finds the holding register empty sets `underrun` and sends the previously sent word again (all zeros if nothing has been sent since reset). A host write clears `underrun`, unless the write falls in the same cycle as such a frame.
- R6: In internal clock mode, the unpolarised clock starts low after reset and toggles every `cfg_div`+1 system cycles.
- R7: `cfg_clk_pol`=1 inverts the clock pin. In internal mode this applies to `sclk_o`. In external mode it applies to how `ext_sclk` is read.
- R8: In internal frame mode, the unpolarised frame sync is updated on each falling edge. It is high for one bit period out of every `cfg_period`+1, starting at the first falling edge after reset. `fsync_o` is that level XOR `cfg_fs_pol`.
- R9: In external frame mode, `ext_fsync` XOR `cfg_fs_pol` is the frame level and `fsync_o` rests at `cfg_fs_pol`. In external clock mode, `sclk_o` rests at `cfg_clk_pol`.
- R10: When `cfg_period`+1 equals the word length and each word is written before its frame, consecutive words are sent with no gap and no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 3 | Word length select |
| cfg_clk_pol | input | 1 | Serial clock pin inversion |
| cfg_fs_pol | input | 1 | Frame sync pin inversion |
| cfg_clk_int | input | 1 | 1: internal serial clock, 0: from ext_sclk |
| cfg_fs_int | input | 1 | 1: internal frame sync, 0: from ext_fsync |
| cfg_div | input | DIV_W | Internal clock half-period minus one, in system cycles |
| cfg_period | input | PER_W | Internal frame period minus one, in bit clocks |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 32 | Host word, right aligned |
| ext_sclk | input | 1 | External serial clock |
| ext_fsync | input | 1 | External frame sync |
| sclk_o | output | 1 | Generated serial clock pin |
| fsync_o | output | 1 | Generated frame sync pin |
| sdata_o | output | 1 | Serial data pin |
| tx_ready | output | 1 | Holding register free for a new word |
| underrun | output | 1 | A frame found no new word |

## Verification
The bench builds the block with its default parameters, DIV_W=8 and PER_W=6. The six-bit period field reaches 31, so a gapless frame period is available for every word length up to 32 bits. The bench uses divisors 0 to 2, which keeps bit clocks short and lets runs cover several full words at each of 8, 12, 16, 20 and 32 bits, one run with only external clock and frame inputs, and an underrun with repeated resend, all well inside the run limit. The inverted pin polarities are covered both on the generated pins and on the external inputs.

// File: rtl/tx_pkg.sv
// Shared constants and helpers for the serial transmitter.
// Assumes the widest word is 32 bits and the length select is 3 bits wide.
package tx_pkg;
    localparam int WORD_MAX = 32;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);

    typedef enum logic [2:0] {
        LEN_8  = 3'd0,
        LEN_12 = 3'd1,
        LEN_16 = 3'd2,
        LEN_20 = 3'd3,
        LEN_24 = 3'd4,
        LEN_32 = 3'd5
    } len_sel_e;

    // Map a length select code to a bit count; unused codes give the widest word.
    function automatic logic [CNT_W-1:0] word_bits(input logic [2:0] sel);
        case (len_sel_e'(sel))
            LEN_8:   return CNT_W'(8);
            LEN_12:  return CNT_W'(12);
            LEN_16:  return CNT_W'(16);
            LEN_20:  return CNT_W'(20);
            LEN_24:  return CNT_W'(24);
            default: return CNT_W'(WORD_MAX);
        endcase
    endfunction
endpackage

// File: rtl/tx_bitclk.sv
// Serial bit clock source. Makes an internal clock by dividing the system clock,
// or follows an external clock pin. It reports one-cycle rise and fall events of
// the unpolarised clock. Assumes the external clock is synchronous to clk and
// slower than clk/2. Reset is synchronous and active low.
module tx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int,
    input  logic             pol,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_sclk,
    output logic             sclk_o,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] dcnt;
    logic             iclk;
    logic             ext_prev;
    logic             ext_raw;
    logic             tick;

    assign ext_raw = ext_sclk ^ pol;
    assign tick    = (dcnt == div);

    // Divider: toggle the internal clock every div+1 system cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
            iclk <= 1'b0;
        end else if (tick) begin
            dcnt <= '0;
            iclk <= ~iclk;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // Remember the previous unpolarised external clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_raw;
    end

    // Select the clock source, form edge events and drive the clock pin.
    always_comb begin
        if (use_int) begin
            rise_ev = tick & ~iclk;
            fall_ev = tick & iclk;
            sclk_o  = iclk ^ pol;
        end else begin
            rise_ev = ext_raw & ~ext_prev;
            fall_ev = ~ext_raw & ext_prev;
            sclk_o  = pol;
        end
    end

    AST_INT_PIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (use_int && !tick && $stable(pol)) |=> $stable(sclk_o)); // R6
endmodule

// File: rtl/tx_framer.sv
// Frame sync source. The internal generator raises a one-bit-period pulse once
// every period+1 bit clocks, updated on falling edges. Otherwise the external
// pin is used. The active level is reported unpolarised. Assumes an external
// frame pin is synchronous to clk. Reset is synchronous and active low.
module tx_framer #(
    parameter int PER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int,
    input  logic             pol,
    input  logic [PER_W-1:0] period,
    input  logic             ext_fsync,
    input  logic             fall_ev,
    output logic             fs_act,
    output logic             fsync_o
);
    logic [PER_W-1:0] fcnt;
    logic             ifs;

    // Count bit clocks and raise the internal pulse at the start of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
            ifs  <= 1'b0;
        end else if (fall_ev) begin
            ifs  <= (fcnt == '0);
            fcnt <= (fcnt == period) ? '0 : fcnt + 1'b1;
        end
    end

    // Pick the frame source and drive the frame pin.
    always_comb begin
        if (use_int) begin
            fs_act  = ifs;
            fsync_o = ifs ^ pol;
        end else begin
            fs_act  = ext_fsync ^ pol;
            fsync_o = pol;
        end
    end

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && ifs && period != '0) |=> !ifs); // R8
endmodule

// File: rtl/tx_shift_core.sv
// Holding and shift register pair. A host write fills the holding register.
// A frame seen on a rising edge copies it, left aligned, into the shift
// register, or reuses the last word if nothing new was written. Falling edges
// send one bit each, MSB first. Assumes the rise and fall events never share
// a cycle. Reset is synchronous and active low.
module tx_shift_core
    import tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          len_sel,
    input  logic                wr_en,
    input  logic [WORD_MAX-1:0] wr_data,
    input  logic                rise_ev,
    input  logic                fall_ev,
    input  logic                fs_act,
    output logic                sdata_o,
    output logic                tx_ready,
    output logic                underrun
);
    logic [WORD_MAX-1:0] hold_q;
    logic                hold_full;
    logic [WORD_MAX-1:0] last_q;
    logic [WORD_MAX-1:0] shreg;
    logic [CNT_W-1:0]    bleft;
    logic                sdata_q;
    logic                ur_q;
    logic                frame;
    logic [CNT_W-1:0]    nbits;
    logic [WORD_MAX-1:0] src;

    assign frame    = rise_ev & fs_act;
    assign nbits    = word_bits(len_sel);
    assign src      = hold_full ? hold_q : last_q;
    assign sdata_o  = sdata_q;
    assign tx_ready = ~hold_full;
    assign underrun = ur_q;

    // Holding register: filled by a host write, emptied when a frame takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            if (frame)
                hold_full <= 1'b0;
            if (wr_en) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
        end
    end

    // Shift register: load on a frame, send one bit on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            last_q  <= '0;
            bleft   <= '0;
            sdata_q <= 1'b0;
        end else if (frame) begin
            shreg  <= src << (CNT_W'(WORD_MAX) - nbits);
            last_q <= src;
            bleft  <= nbits;
        end else if (fall_ev) begin
            if (bleft != '0) begin
                sdata_q <= shreg[WORD_MAX-1];
                shreg   <= shreg << 1;
                bleft   <= bleft - 1'b1;
            end else begin
                sdata_q <= 1'b0;
            end
        end
    end

    // Underrun flag: set by a frame with no new word, cleared by a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ur_q <= 1'b0;
        else if (frame && !hold_full)
            ur_q <= 1'b1;
        else if (wr_en)
            ur_q <= 1'b0;
    end

    AST_READY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_ready); // R4
    AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && hold_full && !wr_en) |=> tx_ready); // R4
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame && !hold_full) |=> underrun); // R5
    AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(frame && !hold_full)) |=> !underrun); // R5
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdata_o)); // R3
endmodule

// File: rtl/serial_tx_port.sv
// Top of the framed serial transmitter. It joins the bit clock source, the
// frame source and the holding/shift core. Assumes configuration only changes
// while reset is held. Reset is synchronous and active low.
module serial_tx_port
    import tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_clk_pol,
    input  logic                cfg_fs_pol,
    input  logic                cfg_clk_int,
    input  logic                cfg_fs_int,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [PER_W-1:0]    cfg_period,
    input  logic                wr_en,
    input  logic [WORD_MAX-1:0] wr_data,
    input  logic                ext_sclk,
    input  logic                ext_fsync,
    output logic                sclk_o,
    output logic                fsync_o,
    output logic                sdata_o,
    output logic                tx_ready,
    output logic                underrun
);
    logic rise_ev;
    logic fall_ev;
    logic fs_act;

    tx_bitclk #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_int  (cfg_clk_int),
        .pol      (cfg_clk_pol),
        .div      (cfg_div),
        .ext_sclk (ext_sclk),
        .sclk_o   (sclk_o),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    tx_framer #(.PER_W(PER_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_int   (cfg_fs_int),
        .pol       (cfg_fs_pol),
        .period    (cfg_period),
        .ext_fsync (ext_fsync),
        .fall_ev   (fall_ev),
        .fs_act    (fs_act),
        .fsync_o   (fsync_o)
    );

    tx_shift_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_sel  (cfg_len),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .fs_act   (fs_act),
        .sdata_o  (sdata_o),
        .tx_ready (tx_ready),
        .underrun (underrun)
    );

    AST_EDGES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_ev && fall_ev)); // R3
endmodule

// File: tb/sim_serial_tx_port.sv
module sim_serial_tx_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_len = 3'd0;
    logic        cfg_clk_pol = 1'b0, cfg_fs_pol = 1'b0;
    logic        cfg_clk_int = 1'b1, cfg_fs_int = 1'b1;
    logic [7:0]  cfg_div = 8'd0;
    logic [5:0]  cfg_period = 6'd7;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic        ext_sclk = 1'b0, ext_fsync = 1'b0;
    logic        sclk_o, fsync_o, sdata_o, tx_ready, underrun;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    serial_tx_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_clk_pol(cfg_clk_pol),
        .cfg_fs_pol(cfg_fs_pol), .cfg_clk_int(cfg_clk_int), .cfg_fs_int(cfg_fs_int),
        .cfg_div(cfg_div), .cfg_period(cfg_period), .wr_en(wr_en), .wr_data(wr_data),
        .ext_sclk(ext_sclk), .ext_fsync(ext_fsync), .sclk_o(sclk_o), .fsync_o(fsync_o),
        .sdata_o(sdata_o), .tx_ready(tx_ready), .underrun(underrun)
    );

    function automatic int bits_of(input logic [2:0] s);
        case (s)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference, advanced once per rising system clock edge.
    int   m_cyc;
    bit   m_raw, m_eprev, m_ifs, m_hfull, m_ur, m_sd;
    int   m_fcnt;
    logic [31:0] m_hold, m_last;
    bit   m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_raw = 0; m_eprev = 0; m_ifs = 0; m_hfull = 0;
            m_ur = 0; m_sd = 0; m_fcnt = 0; m_hold = 0; m_last = 0;
            m_q.delete();
        end else begin
            bit r, f, fa, er, full0, tk;
            int n;
            n = bits_of(cfg_len);
            er = ext_sclk ^ cfg_clk_pol;
            if (cfg_clk_int) begin
                tk = (m_cyc % (int'(cfg_div) + 1)) == int'(cfg_div);
                r = tk && !m_raw;
                f = tk && m_raw;
                if (tk) m_raw = !m_raw;
            end else begin
                r = er && !m_eprev;
                f = !er && m_eprev;
            end
            m_eprev = er;
            m_cyc++;
            fa = cfg_fs_int ? m_ifs : (ext_fsync ^ cfg_fs_pol);
            if (f) begin
                m_sd = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
                m_ifs = (m_fcnt == 0);
                m_fcnt = (m_fcnt == int'(cfg_period)) ? 0 : m_fcnt + 1;
            end
            full0 = m_hfull;
            if (r && fa) begin
                logic [31:0] s;
                s = full0 ? m_hold : m_last;
                m_q.delete();
                for (int i = n - 1; i >= 0; i--) m_q.push_back(s[i]);
                m_last = s;
                m_hfull = 0;
            end
            if (wr_en) begin
                m_hold = wr_data; m_hfull = 1; m_ur = 0;
            end
            if (r && fa && !full0) m_ur = 1;
        end
    end

    // Bench receiver: rebuilds words from the pins, used for word-level checks.
    logic [31:0] rx_q[$];
    bit   rx_prev, rx_on;
    int   rx_cnt;
    logic [31:0] rx_sh;
    bit   cmp_on = 0;

    // Compare every cycle against the reference, away from the clock edge.
    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            rx_prev = 0; rx_on = 0; rx_cnt = 0; rx_sh = 0;
        end else begin
            bit raw, fsr;
            if (cmp_on) begin
                check("R3 sdata", sdata_o, m_sd);
                check("R4 ready", tx_ready, !m_hfull);
                check("R5 underrun", underrun, m_ur);
                check("R6/R7/R9 sclk", sclk_o, cfg_clk_int ? (m_raw ^ cfg_clk_pol) : cfg_clk_pol);
                check("R8/R9 fsync", fsync_o, cfg_fs_int ? (m_ifs ^ cfg_fs_pol) : cfg_fs_pol);
            end
            raw = cfg_clk_int ? (sclk_o ^ cfg_clk_pol) : (ext_sclk ^ cfg_clk_pol);
            fsr = cfg_fs_int ? (fsync_o ^ cfg_fs_pol) : (ext_fsync ^ cfg_fs_pol);
            if (raw && !rx_prev) begin
                if (rx_on) begin
                    rx_sh = {rx_sh[30:0], sdata_o};
                    rx_cnt++;
                    if (rx_cnt == bits_of(cfg_len)) rx_q.push_back(rx_sh);
                end
                if (fsr) begin
                    rx_on = 1; rx_cnt = 0; rx_sh = 0;
                end
            end
            rx_prev = raw;
        end
    end

    task automatic start(input logic [2:0] len, input logic cp, input logic fp,
                         input logic ci, input logic fi, input logic [7:0] dv,
                         input logic [5:0] per);
        @(negedge clk);
        rst_n = 0; wr_en = 0;
        cfg_len = len; cfg_clk_pol = cp; cfg_fs_pol = fp; cfg_clk_int = ci;
        cfg_fs_int = fi; cfg_div = dv; cfg_period = per;
        ext_sclk = cp; ext_fsync = fp;
        repeat (3) @(negedge clk);
        rx_q.delete();
        rst_n = 1;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_en = 1; wr_data = w;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic expect_words(input string req, input logic [31:0] exp[$]);
        foreach (exp[i]) begin
            if (i < rx_q.size()) check(req, rx_q[i], exp[i]);
            else check(req, 32'hxxxx_dead, exp[i]);
        end
    endtask

    task automatic ext_bits(input int count, input int n);
        for (int b = 0; b < count; b++) begin
            @(negedge clk);
            ext_sclk = cfg_clk_pol;
            ext_fsync = ((b % n) == 0) ^ cfg_fs_pol;
            repeat (3) @(negedge clk);
            ext_sclk = !cfg_clk_pol;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w[$];
        // R1: reset values with both polarities inverted
        @(negedge clk);
        cfg_clk_pol = 1; cfg_fs_pol = 1;
        repeat (2) @(negedge clk);
        #1;
        check("R1 ready", tx_ready, 1);
        check("R1 underrun", underrun, 0);
        check("R1 sdata", sdata_o, 0);
        check("R1 sclk", sclk_o, 1);
        check("R1 fsync", fsync_o, 1);
        cmp_on = 1;

        // R10 R2: 16-bit gapless stream, internal clock and frame
        start(3'd2, 0, 0, 1, 1, 8'd1, 6'd15);
        w = '{32'h0000_1234, 32'h0000_ABCD, 32'h0000_8001, 32'h0000_7FFE};
        foreach (w[i]) send(w[i]);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        #1 check("R10 no underrun", underrun, 0);
        repeat (90) @(negedge clk);
        expect_words("R10 gapless words", w);

        // R7 R2: 8-bit words, inverted clock and frame pins, fastest divisor
        start(3'd0, 1, 1, 1, 1, 8'd0, 6'd7);
        w = '{32'hA5, 32'h3C};
        foreach (w[i]) send(w[i]);
        repeat (40) @(negedge clk);
        expect_words("R7 inverted pins words", w);

        // R2: unused length code gives 32-bit words
        start(3'd7, 0, 1, 1, 1, 8'd2, 6'd31);
        w = '{32'hDEAD_BEEF, 32'h1234_5678};
        foreach (w[i]) send(w[i]);
        repeat (400) @(negedge clk);
        expect_words("R2 32-bit words", w);

        // R5: underrun repeats the last word; a write clears the flag
        start(3'd1, 0, 0, 1, 1, 8'd0, 6'd11);
        send(32'h5A3);
        repeat (80) @(negedge clk);
        #1 check("R5 underrun set", underrun, 1);
        w = '{32'h5A3, 32'h5A3};
        expect_words("R5 resend", w);
        send(32'h0F1);
        #1 check("R5 underrun cleared", underrun, 0);
        repeat (60) @(negedge clk);

        // R9: external clock and frame, 20-bit words
        start(3'd3, 1, 0, 0, 0, 8'd0, 6'd0);
        w = '{32'hABCDE, 32'h13579};
        fork
            ext_bits(45, 20);
            begin send(w[0]); send(w[1]); end
        join
        #1 check("R9 sclk rests", sclk_o, 1);
        check("R9 fsync rests", fsync_o, 0);
        expect_words("R9 external words", w);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule